// File: doc/BRIEF.md
# Stride and Next-Line Prefetch Address Sequencer

This block sits beside one cache level and turns a stream of demand access events into prefetch addresses. Each event carries a data address, a hit flag, a flag saying the hit landed on a line that was brought in by a prefetch, a flag saying the missing line is already in flight as a prefetch, and a stride record (signed stride plus confidence count) looked up in an external stride table. The current prefetch distance and degree come in as inputs, as does the number of requests outstanding at this level.

A miss, or a hit on a prefetched line, starts a burst. With a confident stride the burst walks up to degree candidates spaced one stride apart, starting at an offset that depends on whether the stride has only just become confident. Without a confident stride the block asks the cache whether the previous 64-byte line is present and, if so, walks next lines instead. Every candidate is shown on a query port; the cache and the in-flight table answer in the same cycle, and the candidate is issued only when it is absent from both (or in flight for the other level only, in which case the table entry is told to become a both-levels entry). One candidate is handled per cycle.

The FSM has three states. S_IDLE waits for a trigger; transitions: IDLE->PROBE (confident stride, queue below threshold, degree non-zero), IDLE->PREV (stride not confident, degree non-zero), IDLE->IDLE (no trigger, plain hit, queue full, or degree zero). S_PREV presents the previous line on the query port; transitions: PREV->PROBE (line present), PREV->IDLE (line absent). S_PROBE presents one candidate per cycle; transitions: PROBE->PROBE (candidates left), PROBE->IDLE (last candidate, or first issue of a hit-triggered burst).

Top module: `pf_seq_gen`

## Requirements
- R1: A trigger is an accepted event with `evt_hit`=0 (miss) or with `evt_hit`=1 and `evt_pf_hit`=1; an event with `evt_hit`=1 and `evt_pf_hit`=0 issues nothing and changes no counter.
- R2: A stride is confident when `evt_conf` >= 2; for a count of exactly 2 the first candidate is `evt_addr` + distance*stride, for a larger count it is `evt_addr` + (distance+degree-1)*stride.
- R3: A stride burst presents up to `cfg_degree` candidates, each one stride beyond the previous; the stride is signed two's complement and all address arithmetic wraps modulo 2^AW.
- R4: A candidate is issued (`pf_valid`=1, `pf_addr`=candidate) only when `probe_cached`=0 and `probe_flight` is 0 (not in flight) or 2 (in flight for the other level only); codes 1 (same level) and 3 (both levels) block it. `pf_upgrade`=1 accompanies an issue exactly when the code is 2.
- R5: A confident-stride trigger starts a burst only when `outstanding` < QTHRESH (default 35; 10 suits the second level); otherwise nothing is issued and `qlim_count` rises by one.
- R6: Without a confident stride, the line base of `evt_addr` minus 64 is presented first; if `probe_cached`=1 the block presents line base+64, +128, ... up to degree candidates, otherwise nothing; this path ignores `outstanding`.
- R7: A burst started by a hit on a prefetched line ends after its first issued candidate; a miss-triggered burst may issue all degree candidates.
- R8: A miss with `evt_flight_pf`=1 adds one to both `late_count` and `useful_count`; a hit on a prefetched line adds one to `useful_count`. All counters saturate.
- R9: `busy` is high from the cycle after a burst is accepted until it ends; any event arriving while `busy` is high is dropped entirely (no burst, no counter change).
- R10: After reset `busy`, `pf_valid`, `pf_upgrade` are 0 and all counters are 0; no address is issued while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Access event present this cycle |
| evt_addr | input | AW | Data address of the event |
| evt_hit | input | 1 | 1 = hit, 0 = miss |
| evt_pf_hit | input | 1 | Hit landed on a prefetched line |
| evt_flight_pf | input | 1 | Missing line is in flight as a prefetch |
| evt_stride | input | SW | Signed stride from the stride table |
| evt_conf | input | CW | Stride confidence count |
| cfg_distance | input | DW | Current prefetch distance |
| cfg_degree | input | GW | Current prefetch degree |
| outstanding | input | OW | Requests outstanding at this level |
| probe_addr | output | AW | Address presented to cache and in-flight table |
| probe_cached | input | 1 | `probe_addr` is present in the cache |
| probe_flight | input | 2 | In-flight state of `probe_addr`: 0 none, 1 same level, 2 other level, 3 both |
| pf_valid | output | 1 | Prefetch issued this cycle |
| pf_addr | output | AW | Issued prefetch address |
| pf_upgrade | output | 1 | Turn the in-flight entry into a both-levels entry |
| busy | output | 1 | Burst in progress |
| qlim_count | output | CNTW | Stride triggers suppressed by a full queue |
| late_count | output | CNTW | Late prefetches seen |
| useful_count | output | CNTW | Useful prefetches seen |

## Verification
A wrong start offset, step or remaining-candidate count shows on `pf_addr` in the first or following cycles of the burst, and a stuck state shows as `busy` staying high or a burst shorter or longer than the degree, visible within degree+2 cycles of the trigger. A lost one-shot flag shows as a second issue in a hit-triggered burst, and a wrong filter shows as issues of cached or same-level addresses or a missing upgrade. Counter faults appear on the count outputs one cycle after the trigger.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PREV  = 2'd1,
        S_PROBE = 2'd2
    } pf_state_e;

    localparam logic [1:0] FL_NONE  = 2'd0;
    localparam logic [1:0] FL_SAME  = 2'd1;
    localparam logic [1:0] FL_OTHER = 2'd2;
    localparam logic [1:0] FL_BOTH  = 2'd3;
endpackage

// File: rtl/pf_seq_start.sv
module pf_seq_start #(
    parameter int AW = 32,
    parameter int SW = 16,
    parameter int CW = 3,
    parameter int DW = 7,
    parameter int GW = 3
) (
    input  logic [AW-1:0] base_addr,
    input  logic [SW-1:0] stride,
    input  logic [CW-1:0] conf,
    input  logic [DW-1:0] distance,
    input  logic [GW-1:0] degree,
    output logic [AW-1:0] stride_ext,
    output logic [AW-1:0] first_addr
);
    localparam int MW = (DW > GW ? DW : GW) + 1;

    logic [MW-1:0] mult;
    logic [AW-1:0] mult_ext;
    logic [AW-1:0] offset;

    always_comb begin
        stride_ext = {{(AW-SW){stride[SW-1]}}, stride};
        if (conf == CW'(2)) begin
            mult = MW'(distance);
        end else begin
            mult = MW'(distance) + MW'(degree) - MW'(1);
        end
        mult_ext   = AW'(mult);
        offset     = stride_ext * mult_ext;
        first_addr = base_addr + offset;
    end
endmodule

// File: rtl/pf_seq_filter.sv
module pf_seq_filter
    import pf_seq_pkg::*;
(
    input  logic       active,
    input  logic       cached,
    input  logic [1:0] flight,
    output logic       issue,
    output logic       upgrade
);
    logic flight_ok;

    always_comb begin
        unique case (flight)
            FL_NONE:  flight_ok = 1'b1;
            FL_OTHER: flight_ok = 1'b1;
            FL_SAME:  flight_ok = 1'b0;
            FL_BOTH:  flight_ok = 1'b0;
            default:  flight_ok = 1'b0;
        endcase
        issue   = active && !cached && flight_ok;
        upgrade = issue && (flight == FL_OTHER);
    end
endmodule

// File: rtl/pf_seq_counters.sv
module pf_seq_counters #(
    parameter int NUM  = 3,
    parameter int CNTW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM-1:0]      inc,
    output logic [NUM*CNTW-1:0] counts
);
    localparam logic [CNTW-1:0] CMAX = '1;

    for (genvar i = 0; i < NUM; i++) begin : g_cnt
        logic [CNTW-1:0] val;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val <= '0;
            end else if (inc[i] && val != CMAX) begin
                val <= val + CNTW'(1);
            end
        end
        assign counts[i*CNTW +: CNTW] = val;
    end
endmodule

// File: rtl/pf_seq_gen.sv
module pf_seq_gen
    import pf_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SW         = 16,
    parameter int CW         = 3,
    parameter int DW         = 7,
    parameter int GW         = 3,
    parameter int OW         = 8,
    parameter int CNTW       = 16,
    parameter int QTHRESH    = 35,
    parameter int LINE_BYTES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_valid,
    input  logic [AW-1:0]   evt_addr,
    input  logic            evt_hit,
    input  logic            evt_pf_hit,
    input  logic            evt_flight_pf,
    input  logic [SW-1:0]   evt_stride,
    input  logic [CW-1:0]   evt_conf,
    input  logic [DW-1:0]   cfg_distance,
    input  logic [GW-1:0]   cfg_degree,
    input  logic [OW-1:0]   outstanding,
    output logic [AW-1:0]   probe_addr,
    input  logic            probe_cached,
    input  logic [1:0]      probe_flight,
    output logic            pf_valid,
    output logic [AW-1:0]   pf_addr,
    output logic            pf_upgrade,
    output logic            busy,
    output logic [CNTW-1:0] qlim_count,
    output logic [CNTW-1:0] late_count,
    output logic [CNTW-1:0] useful_count
);
    localparam int          LB        = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] LINE_STEP = AW'(LINE_BYTES);
    localparam logic [OW-1:0] QLIM    = OW'(QTHRESH);
    localparam int          NCNT      = 3;

    pf_state_e       state_q, state_d;
    logic [AW-1:0]   cur_q, step_q;
    logic [GW-1:0]   left_q;
    logic            one_shot_q;

    logic            trigger, accept, conf_ok, queue_ok, deg_zero;
    logic [AW-1:0]   line_base, stride_ext, first_addr;
    logic            probing, cand_issue, cand_upgrade;
    logic [NCNT-1:0] cnt_inc;
    logic [NCNT*CNTW-1:0] cnt_bus;

    // Event classification
    always_comb begin
        trigger   = evt_valid && (!evt_hit || evt_pf_hit);
        accept    = trigger && (state_q == S_IDLE);
        conf_ok   = evt_conf >= CW'(2);
        queue_ok  = outstanding < QLIM;
        deg_zero  = cfg_degree == '0;
        line_base = {evt_addr[AW-1:LB], {LB{1'b0}}};
    end

    pf_seq_start #(
        .AW(AW), .SW(SW), .CW(CW), .DW(DW), .GW(GW)
    ) u_start (
        .base_addr  (evt_addr),
        .stride     (evt_stride),
        .conf       (evt_conf),
        .distance   (cfg_distance),
        .degree     (cfg_degree),
        .stride_ext (stride_ext),
        .first_addr (first_addr)
    );

    assign probing = (state_q == S_PROBE);

    pf_seq_filter u_filter (
        .active  (probing),
        .cached  (probe_cached),
        .flight  (probe_flight),
        .issue   (cand_issue),
        .upgrade (cand_upgrade)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept && !deg_zero) begin
                    if (conf_ok) begin
                        if (queue_ok) begin
                            state_d = S_PROBE;
                        end
                    end else begin
                        state_d = S_PREV;
                    end
                end
            end
            S_PREV: begin
                state_d = probe_cached ? S_PROBE : S_IDLE;
            end
            S_PROBE: begin
                if (left_q == GW'(1) || (cand_issue && one_shot_q)) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Burst datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            step_q     <= '0;
            left_q     <= '0;
            one_shot_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        cur_q      <= conf_ok ? first_addr : (line_base - LINE_STEP);
                        step_q     <= conf_ok ? stride_ext : LINE_STEP;
                        left_q     <= cfg_degree;
                        one_shot_q <= evt_hit;
                    end
                end
                S_PREV: begin
                    cur_q <= cur_q + (LINE_STEP << 1);
                end
                S_PROBE: begin
                    cur_q  <= cur_q + step_q;
                    left_q <= left_q - GW'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = 1'b0;
        probe_addr = '0;
        pf_valid   = 1'b0;
        pf_upgrade = 1'b0;
        pf_addr    = cur_q;
        unique case (state_q)
            S_IDLE: ;
            S_PREV: begin
                busy       = 1'b1;
                probe_addr = cur_q;
            end
            S_PROBE: begin
                busy       = 1'b1;
                probe_addr = cur_q;
                pf_valid   = cand_issue;
                pf_upgrade = cand_upgrade;
            end
            default: ;
        endcase
    end

    // Statistics
    always_comb begin
        cnt_inc[0] = accept && conf_ok && !queue_ok;
        cnt_inc[1] = accept && !evt_hit && evt_flight_pf;
        cnt_inc[2] = accept && ((!evt_hit && evt_flight_pf) || evt_pf_hit);
    end

    pf_seq_counters #(.NUM(NCNT), .CNTW(CNTW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cnt_inc),
        .counts (cnt_bus)
    );

    assign qlim_count   = cnt_bus[0*CNTW +: CNTW];
    assign late_count   = cnt_bus[1*CNTW +: CNTW];
    assign useful_count = cnt_bus[2*CNTW +: CNTW];
endmodule

// File: rtl/pf_seq_checker.sv
module pf_seq_checker #(
    parameter int AW   = 32,
    parameter int CNTW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            evt_valid,
    input logic            busy,
    input logic            pf_valid,
    input logic            pf_upgrade,
    input logic            probe_cached,
    input logic [1:0]      probe_flight,
    input logic [CNTW-1:0] qlim_count,
    input logic [CNTW-1:0] late_count,
    input logic [CNTW-1:0] useful_count
);
    localparam logic [CNTW-1:0] CMAX = '1;

    // R10: nothing issued while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pf_valid && !pf_upgrade));

    // R4: an issued candidate is never a cached line
    p_issue_uncached_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !probe_cached);

    // R4: upgrade only with an issue of an other-level entry
    p_upgrade_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_upgrade |-> (pf_valid && probe_flight == 2'd2));

    // R5: the queue-limited count moves by one at a time
    p_qlim_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qlim_count != $past(qlim_count)) |-> (qlim_count == $past(qlim_count) + CNTW'(1)));

    // R8: a late prefetch is also a useful one
    p_late_useful_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (late_count != $past(late_count) && $past(useful_count) != CMAX)
            |-> (useful_count != $past(useful_count)));

    // R9: events during a burst leave the counters alone
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && evt_valid) |=> ($stable(late_count) && $stable(useful_count) && $stable(qlim_count)));
endmodule

bind pf_seq_gen pf_seq_checker #(.AW(AW), .CNTW(CNTW)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_valid    (evt_valid),
    .busy         (busy),
    .pf_valid     (pf_valid),
    .pf_upgrade   (pf_upgrade),
    .probe_cached (probe_cached),
    .probe_flight (probe_flight),
    .qlim_count   (qlim_count),
    .late_count   (late_count),
    .useful_count (useful_count)
);

// File: tb/pf_seq_gen_test.sv
module pf_seq_gen_test;
    localparam int AW = 32, SW = 16, CW = 3, DW = 7, GW = 3, OW = 8, CNTW = 16;
    localparam time CLK_P = 20ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            evt_valid = 1'b0;
    logic [AW-1:0]   evt_addr = '0;
    logic            evt_hit = 1'b0, evt_pf_hit = 1'b0, evt_flight_pf = 1'b0;
    logic [SW-1:0]   evt_stride = '0;
    logic [CW-1:0]   evt_conf = '0;
    logic [DW-1:0]   cfg_distance = 7'd16;
    logic [GW-1:0]   cfg_degree = 3'd2;
    logic [OW-1:0]   outstanding = '0;
    logic [AW-1:0]   probe_addr;
    logic            probe_cached;
    logic [1:0]      probe_flight;
    logic            pf_valid, pf_upgrade, busy;
    logic [AW-1:0]   pf_addr;
    logic [CNTW-1:0] qlim_count, late_count, useful_count;

    int checks = 0;
    int fails  = 0;

    // Environment model: small cache and in-flight table
    logic [AW-1:0] cache_tab [8];
    logic          cache_vld [8];
    logic [AW-1:0] fl_tab    [4];
    logic [1:0]    fl_st     [4];

    // Log of issued prefetches
    logic [AW-1:0] log_addr [16];
    logic          log_upg  [16];
    int            log_n = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        probe_cached = 1'b0;
        for (int i = 0; i < 8; i++)
            if (cache_vld[i] && cache_tab[i] == probe_addr) probe_cached = 1'b1;
        probe_flight = 2'd0;
        for (int i = 0; i < 4; i++)
            if (fl_st[i] != 2'd0 && fl_tab[i] == probe_addr) probe_flight = fl_st[i];
    end

    pf_seq_gen uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
        .evt_hit(evt_hit), .evt_pf_hit(evt_pf_hit), .evt_flight_pf(evt_flight_pf),
        .evt_stride(evt_stride), .evt_conf(evt_conf), .cfg_distance(cfg_distance),
        .cfg_degree(cfg_degree), .outstanding(outstanding), .probe_addr(probe_addr),
        .probe_cached(probe_cached), .probe_flight(probe_flight), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .pf_upgrade(pf_upgrade), .busy(busy),
        .qlim_count(qlim_count), .late_count(late_count), .useful_count(useful_count)
    );

    always @(negedge clk) begin
        if (pf_valid && log_n < 16) begin
            log_addr[log_n] = pf_addr;
            log_upg[log_n]  = pf_upgrade;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_env();
        for (int i = 0; i < 8; i++) begin cache_vld[i] = 1'b0; cache_tab[i] = '0; end
        for (int i = 0; i < 4; i++) begin fl_st[i] = 2'd0; fl_tab[i] = '0; end
        log_n = 0;
    endtask

    // Drive one event for one cycle, return busy seen afterwards, wait for burst end
    task automatic fire(input logic [AW-1:0] a, input logic h, input logic ph,
                        input logic fp, input logic [SW-1:0] s, input logic [CW-1:0] c,
                        output logic busy_seen);
        @(negedge clk);
        evt_addr = a; evt_hit = h; evt_pf_hit = ph; evt_flight_pf = fp;
        evt_stride = s; evt_conf = c; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        busy_seen = busy;
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 busy", 64'(busy), 64'd0);
        chk("R10 pf_valid", 64'(pf_valid), 64'd0);
        chk("R10 qlim", 64'(qlim_count), 64'd0);
        chk("R10 late", 64'(late_count), 64'd0);
        chk("R10 useful", 64'(useful_count), 64'd0);
    endtask

    task automatic t_new_stride();
        logic b;
        clear_env();
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd2, b);
        chk("R9 busy during burst", 64'(b), 64'd1);
        chk("R3 count", 64'(log_n), 64'd2);
        chk("R2 first addr conf2", 64'(log_addr[0]), 64'h1080);
        chk("R3 second addr", 64'(log_addr[1]), 64'h1088);
    endtask

    task automatic t_old_stride();
        logic b;
        clear_env();
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd3, b);
        chk("R2 first addr conf3", 64'(log_addr[0]), 64'h1088);
        chk("R3 second addr conf3", 64'(log_addr[1]), 64'h1090);
    endtask

    task automatic t_negative();
        logic b;
        clear_env();
        cfg_distance = 7'd4;
        fire(32'h100, 1'b0, 1'b0, 1'b0, -16'sd64, 3'd3, b);
        chk("R3 wrap count", 64'(log_n), 64'd2);
        chk("R3 wrap first", 64'(log_addr[0]), 64'hFFFF_FFC0);
        chk("R3 wrap second", 64'(log_addr[1]), 64'hFFFF_FF80);
        cfg_distance = 7'd16;
    endtask

    task automatic t_degree4();
        logic b;
        clear_env();
        cfg_degree = 3'd4;
        fire(32'h2000, 1'b0, 1'b0, 1'b0, 16'd16, 3'd2, b);
        chk("R3 degree4 count", 64'(log_n), 64'd4);
        chk("R3 degree4 last", 64'(log_addr[3]), 64'h2130);
        cfg_degree = 3'd2;
    endtask

    task automatic t_pf_hit();
        logic b;
        logic [CNTW-1:0] u0;
        clear_env();
        u0 = useful_count;
        fire(32'h1000, 1'b1, 1'b1, 1'b0, 16'd8, 3'd2, b);
        chk("R7 one shot count", 64'(log_n), 64'd1);
        chk("R7 one shot addr", 64'(log_addr[0]), 64'h1080);
        chk("R8 useful on pf hit", 64'(useful_count), 64'(u0 + 1'b1));
        clear_env();
        cache_tab[0] = 32'h1080; cache_vld[0] = 1'b1;
        fire(32'h1000, 1'b1, 1'b1, 1'b0, 16'd8, 3'd2, b);
        chk("R7 skip cached then issue count", 64'(log_n), 64'd1);
        chk("R7 skip cached then issue addr", 64'(log_addr[0]), 64'h1088);
    endtask

    task automatic t_filter();
        logic b;
        clear_env();
        fl_tab[0] = 32'h1080; fl_st[0] = 2'd1;
        fl_tab[1] = 32'h1088; fl_st[1] = 2'd2;
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd2, b);
        chk("R4 filter count", 64'(log_n), 64'd1);
        chk("R4 filter addr", 64'(log_addr[0]), 64'h1088);
        chk("R4 upgrade", 64'(log_upg[0]), 64'd1);
        clear_env();
        fl_tab[0] = 32'h1080; fl_st[0] = 2'd3;
        cache_tab[0] = 32'h1088; cache_vld[0] = 1'b1;
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd2, b);
        chk("R4 both blocked", 64'(log_n), 64'd0);
        clear_env();
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd2, b);
        chk("R4 no upgrade when absent", 64'(log_upg[0]), 64'd0);
    endtask

    task automatic t_queue();
        logic b;
        logic [CNTW-1:0] q0;
        clear_env();
        q0 = qlim_count;
        outstanding = 8'd35;
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd2, b);
        chk("R5 full queue no issue", 64'(log_n), 64'd0);
        chk("R5 full queue busy", 64'(b), 64'd0);
        chk("R5 qlim counted", 64'(qlim_count), 64'(q0 + 1'b1));
        clear_env();
        outstanding = 8'd34;
        fire(32'h1000, 1'b0, 1'b0, 1'b0, 16'd8, 3'd2, b);
        chk("R5 below threshold issues", 64'(log_n), 64'd2);
        chk("R5 qlim unchanged", 64'(qlim_count), 64'(q0 + 1'b1));
        outstanding = 8'd0;
    endtask

    task automatic t_sequential();
        logic b;
        logic [CNTW-1:0] q0;
        clear_env();
        cache_tab[0] = 32'h1FC0; cache_vld[0] = 1'b1;
        fire(32'h2010, 1'b0, 1'b0, 1'b0, 16'd8, 3'd1, b);
        chk("R6 seq count", 64'(log_n), 64'd2);
        chk("R6 seq first", 64'(log_addr[0]), 64'h2040);
        chk("R6 seq second", 64'(log_addr[1]), 64'h2080);
        clear_env();
        fire(32'h2010, 1'b0, 1'b0, 1'b0, 16'd8, 3'd0, b);
        chk("R6 prev absent", 64'(log_n), 64'd0);
        clear_env();
        cache_tab[0] = 32'h1FC0; cache_vld[0] = 1'b1;
        q0 = qlim_count;
        outstanding = 8'd50;
        fire(32'h2010, 1'b0, 1'b0, 1'b0, 16'd8, 3'd1, b);
        chk("R6 seq ignores queue", 64'(log_n), 64'd2);
        chk("R6 seq no qlim", 64'(qlim_count), 64'(q0));
        outstanding = 8'd0;
    endtask

    task automatic t_late_and_plain();
        logic b;
        logic [CNTW-1:0] l0, u0;
        clear_env();
        l0 = late_count; u0 = useful_count;
        fire(32'h4000, 1'b0, 1'b0, 1'b1, 16'd8, 3'd0, b);
        chk("R8 late counted", 64'(late_count), 64'(l0 + 1'b1));
        chk("R8 useful with late", 64'(useful_count), 64'(u0 + 1'b1));
        clear_env();
        cache_tab[0] = 32'h1FC0; cache_vld[0] = 1'b1;
        l0 = late_count; u0 = useful_count;
        fire(32'h1000, 1'b1, 1'b0, 1'b1, 16'd8, 3'd2, b);
        chk("R1 plain hit no issue", 64'(log_n), 64'd0);
        chk("R1 plain hit no busy", 64'(b), 64'd0);
        chk("R1 plain hit no count", 64'(useful_count), 64'(u0));
    endtask

    task automatic t_drop();
        logic [CNTW-1:0] l0;
        clear_env();
        cfg_degree = 3'd4;
        l0 = late_count;
        @(negedge clk);
        evt_addr = 32'h3000; evt_hit = 1'b0; evt_pf_hit = 1'b0; evt_flight_pf = 1'b0;
        evt_stride = 16'd8; evt_conf = 3'd2; evt_valid = 1'b1;
        @(negedge clk);
        chk("R9 busy after accept", 64'(busy), 64'd1);
        evt_addr = 32'h5000; evt_flight_pf = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        while (busy) @(negedge clk);
        chk("R9 first burst only", 64'(log_n), 64'd4);
        chk("R9 first burst last", 64'(log_addr[3]), 64'h3098);
        chk("R9 dropped event uncounted", 64'(late_count), 64'(l0));
        cfg_degree = 3'd2;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_env();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_new_stride();
        t_old_stride();
        t_negative();
        t_degree4();
        t_pf_hit();
        t_filter();
        t_queue();
        t_sequential();
        t_late_and_plain();
        t_drop();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule